// File: doc/BRIEF.md
# UART Interrupt Source Identification

This block is the interrupt-source logic of a 16550-compatible serial port. It watches the receive and transmit FIFO status (fill level, empty flag, push and pop strobes), four line-error event pulses and a once-per-character-time tick. From these it keeps a pending flag for each interrupt source. It combines the flags with per-source enable bits, drives one interrupt line, and presents the highest-priority enabled source as a 3-bit identification code with an active-low pending bit. The receive character-timeout counter lives here too. The serial shifters, baud generator, FIFO storage and bus wrapper sit outside. Register accesses arrive as one-cycle read strobes.

A read of the identification register clears only the source that the read reports. If a transmit-empty condition is queued behind a receive source, it stays pending across a read that reports the receive source. The next read after the receive source is serviced then reports transmit-empty. This keeps full-duplex interrupt service from losing the transmit interrupt when both sources arrive together. Enabling the transmit-empty interrupt while the transmit FIFO is already empty raises it at once.

Top module: `uirq_ident_top`

## Requirements
- R1: After reset, `irq` is 0, `iir_pend_n` is 1 and `iir_id` is 3'b000.
- R2: The reported code follows a fixed priority. Line status (3'b011) comes first, then receive data-ready (3'b010), then character timeout (3'b110), then transmit-empty (3'b001). When nothing is pending and enabled, the code is 3'b000.
- R3: Each of the four error pulses (overrun, parity, framing, break) sets the line-status flag on the following clock edge. A read of the identification register leaves the flag set. Only `lsr_rd` clears it, and an error pulse in the same cycle wins over that clear.
- R4: Data-ready is reported while `rx_level` is nonzero and at least `rx_trig`. It disappears as soon as the level falls below the trigger.
- R5: The timeout flag sets when the receive level is nonzero and TO_CHARS (default 4) `char_tick` pulses pass with no push or pop. A push, a pop or an empty FIFO restarts the count, and a pop clears the flag.
- R6: An `iir_rd` in a cycle where `iir_id` reads 3'b001 clears the transmit-empty flag.
- R7: An `iir_rd` that reports a higher-priority source leaves a pending transmit-empty flag set. Transmit-empty is reported once the higher source is gone.
- R8: A rising edge of `ien[1]` while `tx_empty` is 1 sets the transmit-empty flag on that clock edge, with no character written first.
- R9: A rising edge of `tx_empty` sets the transmit-empty flag again, even after an earlier clear by a read.
- R10: The enable bits are `ien[0]` for data-ready and timeout, `ien[1]` for transmit-empty and `ien[2]` for line status. `irq` is 1 and `iir_pend_n` is 0 exactly when some enabled source is pending. A disabled source never shows in `iir_id`.
- R11: The transmit-empty flag is dropped in any cycle where `tx_empty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien | input | 3 | Source enables: [0] receive, [1] transmit-empty, [2] line status |
| rx_level | input | LVL_W (5) | Receive FIFO fill level |
| rx_trig | input | LVL_W (5) | Receive trigger level |
| rx_push | input | 1 | Receive FIFO push strobe |
| rx_pop | input | 1 | Receive FIFO pop strobe |
| char_tick | input | 1 | One pulse per character time |
| err_overrun | input | 1 | Overrun error event |
| err_parity | input | 1 | Parity error event |
| err_framing | input | 1 | Framing error event |
| err_break | input | 1 | Break detected event |
| lsr_rd | input | 1 | Line status register read strobe |
| tx_empty | input | 1 | Transmit holding register / FIFO empty |
| iir_rd | input | 1 | Identification register read strobe |
| irq | output | 1 | Interrupt request |
| iir_pend_n | output | 1 | 0 when an interrupt is pending |
| iir_id | output | 3 | Code of the highest-priority enabled source |

## Verification
A wrong flag shows at the ports in the same cycle it becomes wrong. This is because `iir_id`, `irq` and `iir_pend_n` decode the registered flags combinationally, so comparing against the reference model on every clock exposes any divergence within one cycle. The exception is a flag hidden by a disabled enable or by a higher-priority source. Such a flag only becomes visible once the masking source is cleared, so the directed sequences remove higher sources on purpose, one by one. A timeout counter that is off by one shows up as the timeout code appearing a tick early or late.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  typedef enum logic [2:0] {
    IID_NONE = 3'b000,
    IID_THRE = 3'b001,
    IID_RXD  = 3'b010,
    IID_LINE = 3'b011,
    IID_TMO  = 3'b110
  } iid_e;

  localparam int unsigned IEN_RX   = 0;
  localparam int unsigned IEN_TX   = 1;
  localparam int unsigned IEN_LINE = 2;
  localparam int unsigned IEN_W    = 3;

endpackage

// File: rtl/uirq_rx_timeout.sv
module uirq_rx_timeout #(
  parameter int unsigned TO_CHARS = 4,
  parameter int unsigned LVL_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  output logic             to_pend
);

  localparam int unsigned CNT_W = $clog2(TO_CHARS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TO_CHARS - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TO_CHARS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             to_q, to_d, to_en;
  logic             restart, expire;

  // next-state
  always_comb begin
    restart = rx_push | rx_pop | (rx_level == '0);
    expire  = !restart && char_tick && (cnt_q == CNT_LAST);
    cnt_en  = restart | (char_tick && (cnt_q != CNT_SAT));
    cnt_d   = restart ? '0 : cnt_q + CNT_W'(1);
    to_en   = expire | rx_pop;
    to_d    = expire;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b0;
    end else if (to_en) begin
      to_q <= to_d;
    end
  end

  assign to_pend = to_q;

endmodule

// File: rtl/uirq_src_flags.sv
module uirq_src_flags #(
  parameter int unsigned N_ERR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ERR-1:0] err_evt,
  input  logic             lsr_rd,
  input  logic             tx_empty,
  input  logic             ien_tx,
  input  logic             thre_rd_clr,
  output logic             ls_pend,
  output logic             thre_pend
);

  logic ls_q, ls_d, ls_en;
  logic thre_q, thre_d;
  logic txe_q, ien_tx_q;
  logic any_err, thre_set;

  // next-state
  always_comb begin
    any_err  = |err_evt;
    ls_en    = any_err | lsr_rd;
    ls_d     = any_err;
    thre_set = (tx_empty & ~txe_q) | (ien_tx & ~ien_tx_q & tx_empty);
    thre_d   = thre_set | (thre_q & tx_empty & ~thre_rd_clr);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q <= 1'b0;
    end else if (ls_en) begin
      ls_q <= ls_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_q   <= 1'b0;
      txe_q    <= 1'b0;
      ien_tx_q <= 1'b0;
    end else begin
      thre_q   <= thre_d;
      txe_q    <= tx_empty;
      ien_tx_q <= ien_tx;
    end
  end

  assign ls_pend   = ls_q;
  assign thre_pend = thre_q;

endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
  import uirq_pkg::*;
(
  input  logic             ls_pend,
  input  logic             rxd_lvl,
  input  logic             to_pend,
  input  logic             thre_pend,
  input  logic [IEN_W-1:0] ien,
  output iid_e             id,
  output logic             irq
);

  logic act_ls, act_rxd, act_to, act_thre;

  always_comb begin
    act_ls   = ls_pend   & ien[IEN_LINE];
    act_rxd  = rxd_lvl   & ien[IEN_RX];
    act_to   = to_pend   & ien[IEN_RX];
    act_thre = thre_pend & ien[IEN_TX];
    irq      = act_ls | act_rxd | act_to | act_thre;
    if (act_ls)        id = IID_LINE;
    else if (act_rxd)  id = IID_RXD;
    else if (act_to)   id = IID_TMO;
    else if (act_thre) id = IID_THRE;
    else               id = IID_NONE;
  end

endmodule

// File: rtl/uirq_ident_top.sv
module uirq_ident_top
  import uirq_pkg::*;
#(
  parameter  int unsigned FIFO_DEPTH = 16,
  parameter  int unsigned TO_CHARS   = 4,
  localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       ien,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  input  logic             err_overrun,
  input  logic             err_parity,
  input  logic             err_framing,
  input  logic             err_break,
  input  logic             lsr_rd,
  input  logic             tx_empty,
  input  logic             iir_rd,
  output logic             irq,
  output logic             iir_pend_n,
  output logic [2:0]       iir_id
);

  localparam int unsigned N_ERR = 4;

  logic [N_ERR-1:0] err_evt;
  logic             rxd_lvl;
  logic             to_pend_w, ls_pend_w, thre_pend_w;
  logic             thre_rd_clr;
  logic             irq_w;
  iid_e             id_w;

  always_comb begin
    err_evt     = {err_break, err_framing, err_parity, err_overrun};
    rxd_lvl     = (rx_level != '0) && (rx_level >= rx_trig);
    thre_rd_clr = iir_rd && (id_w == IID_THRE);
  end

  uirq_rx_timeout #(
    .TO_CHARS (TO_CHARS),
    .LVL_W    (LVL_W)
  ) tmo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_level  (rx_level),
    .rx_push   (rx_push),
    .rx_pop    (rx_pop),
    .char_tick (char_tick),
    .to_pend   (to_pend_w)
  );

  uirq_src_flags #(
    .N_ERR (N_ERR)
  ) flags_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_evt     (err_evt),
    .lsr_rd      (lsr_rd),
    .tx_empty    (tx_empty),
    .ien_tx      (ien[IEN_TX]),
    .thre_rd_clr (thre_rd_clr),
    .ls_pend     (ls_pend_w),
    .thre_pend   (thre_pend_w)
  );

  uirq_prio_enc enc_i (
    .ls_pend   (ls_pend_w),
    .rxd_lvl   (rxd_lvl),
    .to_pend   (to_pend_w),
    .thre_pend (thre_pend_w),
    .ien       (ien),
    .id        (id_w),
    .irq       (irq_w)
  );

  assign irq        = irq_w;
  assign iir_pend_n = ~irq_w;
  assign iir_id     = id_w;

endmodule

// File: rtl/uirq_ident_chk.sv
module uirq_ident_chk #(
  parameter int unsigned LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       ien,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] rx_trig,
  input logic [3:0]       errs,
  input logic             lsr_rd,
  input logic             tx_empty,
  input logic             iir_rd,
  input logic             irq,
  input logic [2:0]       iir_id,
  input logic             ls_pend,
  input logic             thre_pend
);

  p_ls_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_pend && !lsr_rd) |=> ls_pend);

  p_ls_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && (errs == 4'b0)) |=> !ls_pend);

  p_line_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_pend && ien[2]) |-> (iir_id == 3'b011));

  p_rxd_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[0] && (rx_level != '0) && (rx_level >= rx_trig)) |-> irq);

  p_thre_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && (iir_id != 3'b001) && thre_pend && tx_empty) |=> thre_pend);

  p_thre_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && (iir_id == 3'b001) && $past(tx_empty) && !$rose(ien[1])) |=> !thre_pend);

  p_arm_on_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ien[1]) && tx_empty) |=> thre_pend);

  p_tx_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ien[1] |-> (iir_id != 3'b001));

endmodule

bind uirq_ident_top uirq_ident_chk #(.LVL_W(LVL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ien       (ien),
  .rx_level  (rx_level),
  .rx_trig   (rx_trig),
  .errs      ({err_break, err_framing, err_parity, err_overrun}),
  .lsr_rd    (lsr_rd),
  .tx_empty  (tx_empty),
  .iir_rd    (iir_rd),
  .irq       (irq),
  .iir_id    (iir_id),
  .ls_pend   (ls_pend_w),
  .thre_pend (thre_pend_w)
);

// File: tb/uirq_ident_top_tb_top.sv
`timescale 1ns/1ps
module uirq_ident_top_tb_top;

  localparam int LW = 5;
  localparam logic [2:0] C_NONE = 3'b000, C_THRE = 3'b001, C_RXD = 3'b010,
                         C_LINE = 3'b011, C_TMO = 3'b110;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    ien;
  logic [LW-1:0] rx_level, rx_trig;
  logic          rx_push, rx_pop, char_tick;
  logic [3:0]    errs;
  logic          lsr_rd, tx_empty, iir_rd;
  logic          irq, iir_pend_n;
  logic [2:0]    iir_id;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    cmp_on = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  uirq_ident_top dut_i (
    .clk(clk), .rst_n(rst_n), .ien(ien), .rx_level(rx_level), .rx_trig(rx_trig),
    .rx_push(rx_push), .rx_pop(rx_pop), .char_tick(char_tick),
    .err_overrun(errs[0]), .err_parity(errs[1]), .err_framing(errs[2]), .err_break(errs[3]),
    .lsr_rd(lsr_rd), .tx_empty(tx_empty), .iir_rd(iir_rd),
    .irq(irq), .iir_pend_n(iir_pend_n), .iir_id(iir_id)
  );

  // behavioural reference model
  bit m_line, m_tmo, m_tx, m_txe_prev, m_en_prev;
  int m_ticks;

  function automatic logic [2:0] model_code();
    if (m_line && ien[2]) return C_LINE;
    if (ien[0] && int'(rx_level) > 0 && int'(rx_level) >= int'(rx_trig)) return C_RXD;
    if (ien[0] && m_tmo) return C_TMO;
    if (ien[1] && m_tx) return C_THRE;
    return C_NONE;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = 0; m_tmo = 0; m_tx = 0; m_txe_prev = 0; m_en_prev = 0; m_ticks = 0;
    end else begin
      bit quiet, fire, rd_tx, arm;
      rd_tx = iir_rd && (model_code() == C_THRE);
      quiet = !(rx_push || rx_pop || int'(rx_level) == 0);
      fire  = quiet && char_tick && (m_ticks == 3);
      if (!quiet) m_ticks = 0;
      else if (char_tick && m_ticks < 4) m_ticks = m_ticks + 1;
      if (fire) m_tmo = 1; else if (rx_pop) m_tmo = 0;
      if (errs != 0) m_line = 1; else if (lsr_rd) m_line = 0;
      arm = (tx_empty && !m_txe_prev) || (ien[1] && !m_en_prev && tx_empty);
      if (arm) m_tx = 1;
      else if (!tx_empty || rd_tx) m_tx = 0;
      m_txe_prev = tx_empty;
      m_en_prev  = ien[1];
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [2:0] e;
      e = model_code();
      n_chk++;
      if (iir_id !== e || irq !== (e != 0) || iir_pend_n !== (e == 0)) begin
        n_fail++;
        $display("FAIL %s model: id=%b irq=%b pend_n=%b expected id=%b", cur_req, iir_id, irq, iir_pend_n, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [2:0] e);
    #1;
    n_chk++;
    if (iir_id !== e || irq !== (e != 0) || iir_pend_n !== (e == 0)) begin
      n_fail++;
      $display("FAIL %s: id=%b irq=%b pend_n=%b expected id=%b irq=%b", req, iir_id, irq, iir_pend_n, e, (e != 0));
    end
  endtask

  task automatic rd_iir();   iir_rd = 1;    step(); iir_rd = 0;    endtask
  task automatic rd_lsr();   lsr_rd = 1;    step(); lsr_rd = 0;    endtask
  task automatic tick();     char_tick = 1; step(); char_tick = 0; step(); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; ien = 0; rx_level = 0; rx_trig = 4; rx_push = 0; rx_pop = 0;
    char_tick = 0; errs = 0; lsr_rd = 0; tx_empty = 0; iir_rd = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1", C_NONE);
    cmp_on = 1;

    // transmit-empty arming, clearing, re-arming
    cur_req = "R8";
    tx_empty = 1; step(); chk("R10", C_NONE);
    ien = 3'b010; step(); chk("R10", C_THRE);
    rd_iir(); chk("R6", C_NONE);
    ien = 3'b000; step(); ien = 3'b010; step(); chk("R8", C_THRE);
    tx_empty = 0; step(); chk("R11", C_NONE);
    tx_empty = 1; step(); chk("R9", C_THRE);
    rd_iir(); chk("R6", C_NONE);
    tx_empty = 0; step(); tx_empty = 1; step(); chk("R9", C_THRE);

    // simultaneous receive and transmit
    cur_req = "R7";
    ien = 3'b011; rx_level = 3; step(); chk("R4", C_THRE);
    rx_level = 4; chk("R4", C_RXD);
    rd_iir(); chk("R7", C_RXD);
    rx_level = 0; chk("R7", C_THRE);
    rd_iir(); chk("R6", C_NONE);

    // line status from each error kind
    cur_req = "R3";
    ien = 3'b111;
    for (int k = 0; k < 4; k++) begin
      errs = 4'(1 << k); step(); errs = 0; chk("R3", C_LINE);
      rd_iir(); chk("R3", C_LINE);
      rd_lsr(); chk("R3", C_NONE);
    end

    // character timeout
    cur_req = "R5";
    ien = 3'b001; rx_level = 2;
    repeat (3) tick();
    chk("R5", C_NONE);
    rx_push = 1; rx_level = 3; step(); rx_push = 0;
    repeat (3) tick();
    chk("R5", C_NONE);
    tick(); chk("R5", C_TMO);
    rx_level = 5; chk("R2", C_RXD);
    rx_level = 3; chk("R5", C_TMO);
    rx_pop = 1; rx_level = 2; step(); rx_pop = 0; chk("R5", C_NONE);

    // enables mask sources
    cur_req = "R10";
    ien = 3'b000; errs = 4'b0001; step(); errs = 0; chk("R10", C_NONE);
    ien = 3'b100; chk("R10", C_LINE);
    rd_lsr(); chk("R10", C_NONE);

    // all three together, removed in priority order
    cur_req = "R2";
    ien = 3'b111; rx_level = 0;
    tx_empty = 0; step(); tx_empty = 1; step();
    errs = 4'b1000; step(); errs = 0; rx_level = 6;
    chk("R2", C_LINE);
    rd_lsr(); chk("R2", C_RXD);
    rx_level = 0; chk("R2", C_THRE);
    rd_iir(); chk("R6", C_NONE);

    // pseudo-random traffic checked against the model each cycle
    cur_req = "R7";
    for (int i = 0; i < 4000; i++) begin
      int lvl;
      lvl = int'(rx_level);
      if (i % 50 == 0) ien = 3'($urandom_range(0, 7));
      if (i % 300 == 0) rx_trig = 5'($urandom_range(1, 14));
      rx_push = ($urandom_range(0, 3) == 0) && lvl < 16;
      rx_pop  = ($urandom_range(0, 4) == 0) && lvl > 0 && !rx_push;
      if (rx_push) lvl++;
      if (rx_pop)  lvl--;
      rx_level  = 5'(lvl);
      char_tick = ($urandom_range(0, 2) == 0);
      errs      = ($urandom_range(0, 39) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'b0;
      if ($urandom_range(0, 16) == 0) tx_empty = ~tx_empty;
      iir_rd = ($urandom_range(0, 5) == 0);
      lsr_rd = ($urandom_range(0, 8) == 0);
      step();
    end
    rx_push = 0; rx_pop = 0; char_tick = 0; errs = 0; iir_rd = 0; lsr_rd = 0;
    step();

    cmp_on = 0;
    done = 1;
    summary();
    $finish;
  end

endmodule